// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps the time of day as six 8421 BCD digits (hours, minutes and seconds, two digits each). The time wraps once every 24 hours. It runs entirely on a 32768 Hz reference clock. A binary prescaler first divides that clock down to a 2 Hz tick. A further divide-by-two stage then turns the 2 Hz tick into the 1 Hz tick that advances the seconds. Every tick and carry is a one-cycle enable inside a single clock domain. No counter stage clocks another.

The seconds and minutes pairs each count from 00 to 59. The hours pair counts from 00 to 23. Each pair passes a carry to the next pair up when it wraps. The hours tens and units digits are decoded as one value, so that 23 returns to 00. An external time-set block may pulse separate minute-advance and hour-advance inputs. Each pulse steps its own unit by one and never carries into the unit above. Segment decoding, display drive and the oscillator are left to other blocks.

The prescaler length is a parameter, `DIV_STAGES`, and its default is 14. A test environment can shorten it so that days pass in a few thousand cycles.

Top module: `tod_clock_chain`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the following hold from that edge on: all six digit outputs are 0, `tick_1hz` is low, and the prescaler count is cleared.
- R2: With `rst` low, `tick_1hz` is high for exactly one cycle in every 2^(DIV_STAGES+1) cycles. With the default this is 32768 cycles, which is 1 s. The tick is high in the cycle that follows the k-th rising edge after reset, for every k with k mod 2^(DIV_STAGES+1) = 2^(DIV_STAGES+1) − 1.
- R3: Each digit is a 4-bit 8421 BCD value. The seconds and minutes pairs stay within 00 to 59, and the hours pair stays within 00 to 23.
- R4: The seconds pair advances by one on each edge that ends a tick cycle. Units 9 becomes 0 and increments the tens. The value 59 becomes 00 and advances the minutes on the same edge.
- R5: The minutes pair steps in the same way when the seconds carry. When the seconds carry while the minutes are 59, the minutes become 00 and the hours advance on the same edge.
- R6: The hours units pass from 9 to 0 with a tens increment, and 23 becomes 00. A tick at 23:59:59 produces 00:00:00 on the next edge.
- R7: Each cycle with `adv_min` high advances the minutes by one on the next edge. In that case 59 becomes 00 and the hours are left unchanged. The seconds are not affected.
- R8: Each cycle with `adv_hour` high advances the hours by one on the next edge, and 23 becomes 00. The minutes and seconds are not affected.
- R9: A cycle in which `adv_min` coincides with a seconds carry advances the minutes by exactly one. A wrap of the minutes from 59 in that cycle still carries into the hours.
- R10: The digits change only on an edge that ends a cycle in which `tick_1hz`, `adv_min` or `adv_hour` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_min | input | 1 | Minute-advance enable from the time-set block, one step per high cycle |
| adv_hour | input | 1 | Hour-advance enable from the time-set block, one step per high cycle |
| sec_ones | output | 4 | Seconds units, BCD |
| sec_tens | output | 4 | Seconds tens, BCD |
| min_ones | output | 4 | Minutes units, BCD |
| min_tens | output | 4 | Minutes tens, BCD |
| hr_ones | output | 4 | Hours units, BCD |
| hr_tens | output | 4 | Hours tens, BCD |
| tick_1hz | output | 1 | One-cycle 1 Hz strobe, high in the cycle before the seconds step |

## Verification
The strobe `tick_1hz` is decoded directly from the prescaler registers. It is therefore due in the same cycle that the prescaler count reaches its last value. All digit updates, whether caused by the tick or by an advance input, appear one edge after the enabling cycle. A whole chain of carries from the seconds up to the hours also settles within that one edge. The bench samples outputs and drives inputs at the falling edge. At each falling edge it compares the strobe with the cycle count since reset. It then steps a reference time model using the enables of the cycle just ended, and compares all six digits at the next falling edge. The prescaler is shortened to two stages, so one second lasts 8 cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t ones;
    } bcd_pair_t;

    localparam int NUM_PAIRS = 3;
    localparam int PAIR_SEC  = 0;
    localparam int PAIR_MIN  = 1;
    localparam int PAIR_HR   = 2;

    function automatic bcd_t pair_top_tens(input int idx);
        return (idx == PAIR_HR) ? 4'd2 : 4'd5;
    endfunction

    function automatic bcd_t pair_top_ones(input int idx);
        return (idx == PAIR_HR) ? 4'd3 : 4'd9;
    endfunction

    function automatic bcd_pair_t pair_next(input bcd_pair_t cur, input logic at_top);
        bcd_pair_t nxt;
        if (at_top) begin
            nxt = '0;
        end else if (cur.ones == 4'd9) begin
            nxt.tens = cur.tens + 4'd1;
            nxt.ones = 4'd0;
        end else begin
            nxt.tens = cur.tens;
            nxt.ones = cur.ones + 4'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int DIV_STAGES = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick_sec
);
    logic [DIV_STAGES-1:0] stage_cnt;
    logic                  tick_half;
    logic                  half_phase;

    assign tick_half = &stage_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_cnt  <= '0;
            half_phase <= 1'b0;
        end else begin
            stage_cnt <= stage_cnt + 1'b1;
            if (tick_half) begin
                half_phase <= ~half_phase;
            end
        end
    end

    assign tick_sec = tick_half & half_phase;
endmodule

// File: rtl/tod_bcd_pair.sv
module tod_bcd_pair
    import tod_pkg::*;
#(
    parameter bcd_t TOP_TENS = 4'd5,
    parameter bcd_t TOP_ONES = 4'd9
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output bcd_pair_t value,
    output logic      at_top
);
    assign at_top = (value.tens == TOP_TENS) && (value.ones == TOP_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (step) begin
            value <= pair_next(value, at_top);
        end
    end
endmodule

// File: rtl/tod_clock_chain.sv
module tod_clock_chain
    import tod_pkg::*;
#(
    parameter int DIV_STAGES = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv_min,
    input  logic       adv_hour,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens,
    output logic       tick_1hz
);
    logic                 tick_sec;
    logic [NUM_PAIRS-1:0] pair_step;
    logic [NUM_PAIRS-1:0] pair_top;
    logic                 carry_sec;
    logic                 carry_min;
    bcd_pair_t            pair_val [NUM_PAIRS];

    tod_prescaler #(
        .DIV_STAGES(DIV_STAGES)
    ) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .tick_sec(tick_sec)
    );

    always_comb begin
        carry_sec          = tick_sec & pair_top[PAIR_SEC];
        carry_min          = carry_sec & pair_top[PAIR_MIN];
        pair_step[PAIR_SEC] = tick_sec;
        pair_step[PAIR_MIN] = carry_sec | adv_min;
        pair_step[PAIR_HR]  = carry_min | adv_hour;
    end

    for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
        tod_bcd_pair #(
            .TOP_TENS(pair_top_tens(gi)),
            .TOP_ONES(pair_top_ones(gi))
        ) u_pair (
            .clk   (clk),
            .rst   (rst),
            .step  (pair_step[gi]),
            .value (pair_val[gi]),
            .at_top(pair_top[gi])
        );
    end

    assign sec_ones = pair_val[PAIR_SEC].ones;
    assign sec_tens = pair_val[PAIR_SEC].tens;
    assign min_ones = pair_val[PAIR_MIN].ones;
    assign min_tens = pair_val[PAIR_MIN].tens;
    assign hr_ones  = pair_val[PAIR_HR].ones;
    assign hr_tens  = pair_val[PAIR_HR].tens;
    assign tick_1hz = tick_sec;
endmodule

// File: rtl/tod_clock_chain_chk.sv
module tod_clock_chain_chk #(
    parameter int DIV_STAGES = 14
) (
    input logic       clk,
    input logic       rst,
    input logic       adv_min,
    input logic       adv_hour,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] hr_tens,
    input logic       tick_1hz
);
    localparam int PERIOD = 1 << (DIV_STAGES + 1);
    localparam int GAP_W  = DIV_STAGES + 2;

    logic [GAP_W-1:0] gap_cnt;
    logic             rst_q;
    logic             all_zero;
    logic             sec_top;
    logic             min_top;
    logic             hr_top;

    assign all_zero = (sec_ones == 4'd0) && (sec_tens == 4'd0) && (min_ones == 4'd0) &&
                      (min_tens == 4'd0) && (hr_ones == 4'd0) && (hr_tens == 4'd0);
    assign sec_top  = (sec_tens == 4'd5) && (sec_ones == 4'd9);
    assign min_top  = (min_tens == 4'd5) && (min_ones == 4'd9);
    assign hr_top   = (hr_tens == 4'd2) && (hr_ones == 4'd3);

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || tick_1hz) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1: after a reset edge the digits are cleared and the strobe is low
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_clear_r1: assert (all_zero && !tick_1hz)
                else $error("reset state not cleared");
        end
    end

    p_tick_period_r2: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |-> (gap_cnt == GAP_W'(PERIOD - 1)));

    p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |=> !tick_1hz);

    p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
        (sec_ones <= 4'd9) && (sec_tens <= 4'd5) && (min_ones <= 4'd9) &&
        (min_tens <= 4'd5) && (hr_ones <= 4'd9) &&
        ((hr_tens < 4'd2) || ((hr_tens == 4'd2) && (hr_ones <= 4'd3))));

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && sec_top) |=> ((sec_ones == 4'd0) && (sec_tens == 4'd0)));

    p_full_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && sec_top && min_top && hr_top && !adv_min && !adv_hour) |=> all_zero);

    p_min_adv_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (adv_min && !adv_hour && !tick_1hz && min_top) |=>
        ((min_ones == 4'd0) && (min_tens == 4'd0) && $stable(hr_ones) && $stable(hr_tens)));

    p_hour_adv_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (adv_hour && !adv_min && !tick_1hz && hr_top) |=>
        ((hr_ones == 4'd0) && (hr_tens == 4'd0) && $stable(min_ones) && $stable(min_tens)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !adv_min && !adv_hour) |=>
        ($stable(sec_ones) && $stable(sec_tens) && $stable(min_ones) &&
         $stable(min_tens) && $stable(hr_ones) && $stable(hr_tens)));
endmodule

bind tod_clock_chain tod_clock_chain_chk #(
    .DIV_STAGES(DIV_STAGES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv_min (adv_min),
    .adv_hour(adv_hour),
    .sec_ones(sec_ones),
    .sec_tens(sec_tens),
    .min_ones(min_ones),
    .min_tens(min_tens),
    .hr_ones (hr_ones),
    .hr_tens (hr_tens),
    .tick_1hz(tick_1hz)
);

// File: tb/test_tod_clock_chain.sv
module test_tod_clock_chain;
    localparam int DIV    = 2;
    localparam int PERIOD = 1 << (DIV + 1);

    logic       clk;
    logic       rst;
    logic       adv_min;
    logic       adv_hour;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
    logic       tick_1hz;

    int checks;
    int errors;
    int ms, mm, mh;
    int edges;
    bit done;

    tod_clock_chain #(
        .DIV_STAGES(DIV)
    ) i_tod_clock_chain (
        .clk     (clk),
        .rst     (rst),
        .adv_min (adv_min),
        .adv_hour(adv_hour),
        .sec_ones(sec_ones),
        .sec_tens(sec_tens),
        .min_ones(min_ones),
        .min_tens(min_tens),
        .hr_ones (hr_ones),
        .hr_tens (hr_tens),
        .tick_1hz(tick_1hz)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " sec_ones"}, int'(sec_ones), ms % 10);
        check({tag, " sec_tens"}, int'(sec_tens), ms / 10);
        check({tag, " min_ones"}, int'(min_ones), mm % 10);
        check({tag, " min_tens"}, int'(min_tens), mm / 10);
        check({tag, " hr_ones"},  int'(hr_ones),  mh % 10);
        check({tag, " hr_tens"},  int'(hr_tens),  mh / 10);
    endtask

    // reference time model, stepped with the enables of one cycle
    task automatic model_step(input bit tk, input bit am, input bit ah);
        bit cs, cm;
        cs = tk && (ms == 59);
        if (tk) ms = (ms + 1) % 60;
        cm = cs && (mm == 59);
        if (cs || am) mm = (mm + 1) % 60;
        if (cm || ah) mh = (mh + 1) % 24;
    endtask

    // one clock cycle: called and returning at a falling edge
    task automatic cyc(input bit am, input bit ah, input string tag);
        bit tk_exp;
        tk_exp = ((edges % PERIOD) == PERIOD - 1);
        check("R2 tick_1hz", int'(tick_1hz), int'(tk_exp));
        adv_min  = am;
        adv_hour = ah;
        @(posedge clk);
        edges++;
        @(negedge clk);
        adv_min  = 1'b0;
        adv_hour = 1'b0;
        model_step(tk_exp, am, ah);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        adv_min  = 1'b0;
        adv_hour = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ms = 0; mm = 0; mh = 0;
        compare_all("R1 in reset");
        check("R1 tick in reset", int'(tick_1hz), 0);
        rst   = 1'b0;
        edges = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        repeat (5) cyc(1'b1, 1'b1, "R1 advance");
        do_reset();
        compare_all("R1 after reset");
    endtask

    task automatic t_tick_rate();
        do_reset();
        repeat (2 * PERIOD) cyc(1'b0, 1'b0, "R2");
        check("R2 two seconds", int'(sec_ones), 2);
    endtask

    task automatic t_hold();
        do_reset();
        repeat (PERIOD - 1) cyc(1'b0, 1'b0, "R10 hold");
        check("R10 still zero", int'(sec_ones), 0);
    endtask

    task automatic t_seconds_wrap();
        do_reset();
        for (int n = 0; n < 70 * PERIOD && ms != 59; n++) cyc(1'b0, 1'b0, "R3");
        for (int n = 0; n < 2 * PERIOD && ms != 0; n++) cyc(1'b0, 1'b0, "R4");
        check("R4 seconds zero", int'(sec_tens) * 10 + int'(sec_ones), 0);
        check("R4 minute carry", int'(min_ones), 1);
    endtask

    task automatic t_minute_advance();
        do_reset();
        repeat (59) cyc(1'b1, 1'b0, "R7");
        check("R7 min at 59", int'(min_tens) * 10 + int'(min_ones), 59);
        cyc(1'b1, 1'b0, "R7 wrap");
        check("R7 min wrap", int'(min_tens) * 10 + int'(min_ones), 0);
        check("R7 hours kept", int'(hr_tens) * 10 + int'(hr_ones), 0);
    endtask

    task automatic t_minute_carry();
        do_reset();
        repeat (59) cyc(1'b1, 1'b0, "R5 set");
        for (int n = 0; n < 70 * PERIOD && mm != 0; n++) cyc(1'b0, 1'b0, "R5");
        check("R5 hour carry", int'(hr_ones), 1);
    endtask

    task automatic t_hour_advance();
        do_reset();
        repeat (23) cyc(1'b0, 1'b1, "R8");
        check("R8 hr at 23", int'(hr_tens) * 10 + int'(hr_ones), 23);
        cyc(1'b0, 1'b1, "R8 wrap");
        check("R8 hr wrap", int'(hr_tens) * 10 + int'(hr_ones), 0);
    endtask

    task automatic t_full_wrap();
        do_reset();
        repeat (23) cyc(1'b0, 1'b1, "R6 set");
        repeat (59) cyc(1'b1, 1'b0, "R6 set");
        for (int n = 0; n < 70 * PERIOD && mh == 23; n++) cyc(1'b0, 1'b0, "R6");
        check("R6 sec", int'(sec_tens) * 10 + int'(sec_ones), 0);
        check("R6 min", int'(min_tens) * 10 + int'(min_ones), 0);
        check("R6 hr",  int'(hr_tens) * 10 + int'(hr_ones), 0);
    endtask

    task automatic t_coincide();
        do_reset();
        repeat (59) cyc(1'b1, 1'b0, "R9 set");
        for (int n = 0; n < 70 * PERIOD && !(ms == 59 && (edges % PERIOD) == PERIOD - 1); n++)
            cyc(1'b0, 1'b0, "R9");
        cyc(1'b1, 1'b0, "R9 coincide");
        check("R9 min once", int'(min_tens) * 10 + int'(min_ones), 0);
        check("R9 hour carry", int'(hr_ones), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; done = 1'b0; edges = 0;
        rst = 1'b1; adv_min = 1'b0; adv_hour = 1'b0;
        ms = 0; mm = 0; mh = 0;
        @(negedge clk);
        t_reset_state();
        t_tick_rate();
        t_hold();
        t_seconds_wrap();
        t_minute_advance();
        t_minute_carry();
        t_hour_advance();
        t_full_wrap();
        t_coincide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule